// File: doc/BRIEF.md
# Connection Memory Bulk Initialiser

This block fills every word of a switch's connection memory with one value, driven by a single register command instead of hundreds of separate processor writes. Software first sets an arm bit in the control register. It then writes the mode register with a 5-bit fill pattern and a start bit of 1, both in the same write. The start bit's 0-to-1 change is the trigger. Nothing happens until the next frame pulse. From the cycle after that pulse, the block writes one word per clock over all streams and channels. Each word holds the pattern in its top five bits and zeros in its lower eleven bits.

The run lasts two frame periods. At the second frame pulse after the fill began, the block clears the start bit by itself, and software reads that as completion. Clearing either the start bit or the arm bit stops the run at once.

The sequencer has four states:

- ST_IDLE: no run is in progress.
- ST_WAIT_FRAME: the block has been triggered and waits for a frame pulse.
- ST_FILL: the block writes one word per clock.
- ST_HOLD: the fill is finished and the block waits out the second frame.

Its transitions are:

- trigger: ST_IDLE to ST_WAIT_FRAME.
- frame_sync: ST_WAIT_FRAME to ST_FILL.
- fill_end: ST_FILL to ST_HOLD, at the last word.
- frame_end: ST_HOLD to ST_IDLE, which clears the start bit.
- abort: any busy state to ST_IDLE.

Top module: `cmbp_block_prog`

## Requirements
- R1: After reset, arm_q, start_q, pattern_q and busy are 0, and cm_we is low.
- R2: A mode write with mode_start_in=1 while start_q is 0 and arm_q is 1 raises busy on the next cycle. No connection memory write happens before the next frame_pulse.
- R3: The first write occurs in the cycle after the frame_pulse that is sampled while waiting. Writes then occur on consecutive cycles to addresses 0,1,2,…,511, where cm_addr = {stream[1:0], channel[6:0]}. Each address is written exactly once.
- R4: Every written word is {pattern[4:0], 11'b0}: bits 15..11 carry the pattern latched at the trigger, and bits 10..0 are zero.
- R5: start_q stays 1 through the first frame_pulse after the fill began. It returns to 0, and busy drops with it, one cycle after the second such frame_pulse is sampled.
- R6: A start write while arm_q is 0 writes nothing to the memory and leaves busy at 0, while start_q reads back 1.
- R7: Writing mode_start_in=0 during a run stops all memory writes from the next cycle and returns busy to 0.
- R8: Writing ctl_arm_in=0 during a run stops all memory writes from the next cycle and returns busy to 0, while start_q stays 1.
- R9: Setting arm while start_q is already 1 does not start a run: only a 0-to-1 start write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_arm_in | input | 1 | Arm bit value for a control write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_start_in | input | 1 | Start bit value for a mode write |
| mode_pattern_in | input | 5 | Fill pattern for a mode write |
| frame_pulse | input | 1 | One-cycle frame boundary pulse |
| cm_we | output | 1 | Connection memory write enable |
| cm_addr | output | 9 | Connection memory word address {stream, channel} |
| cm_wdata | output | 16 | Connection memory write data |
| arm_q | output | 1 | Arm bit readback |
| start_q | output | 1 | Start bit readback (self-clearing) |
| pattern_q | output | 5 | Pattern field readback |
| busy | output | 1 | Run in progress |

## Verification
The assertions assume three things about the inputs:

- frame_pulse is a single-cycle strobe.
- During a run, the mode register is written only to clear the start bit, and the written value repeats the same pattern.
- The start bit is never cleared by a mode write in the same cycle as the self-clear.

The stimulus meets these assumptions as follows:

- It spaces frame pulses 600 clocks apart, which is longer than the 512-word fill.
- It drives every register write from a negative-edge task.
- It never writes the mode register during a run except for the abort case.

// File: rtl/cmbp_pkg.sv
package cmbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_FRAME = 2'd1,
        ST_FILL       = 2'd2,
        ST_HOLD       = 2'd3
    } cmbp_state_e;

    localparam int FILL_FRAMES = 2;

endpackage

// File: rtl/cmbp_regs.sv
module cmbp_regs #(
    parameter int PAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_arm_in,
    input  logic             mode_wr,
    input  logic             mode_start_in,
    input  logic [PAT_W-1:0] mode_pattern_in,
    input  logic             done,
    output logic             arm_q,
    output logic             start_q,
    output logic [PAT_W-1:0] pattern_q,
    output logic             trig
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            start_q   <= 1'b0;
            pattern_q <= '0;
        end else begin
            if (ctl_wr) begin
                arm_q <= ctl_arm_in;
            end
            if (mode_wr) begin
                start_q   <= mode_start_in;
                pattern_q <= mode_pattern_in;
            end else if (done) begin
                start_q <= 1'b0;
            end
        end
    end

    // rising start write, honoured only while armed
    always_comb begin
        trig = mode_wr && mode_start_in && !start_q && arm_q;
    end

endmodule

// File: rtl/cmbp_addr_gen.sv
module cmbp_addr_gen #(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 128,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int ST_W    = (STREAMS > 1) ? $clog2(STREAMS) : 1,
    localparam int ADDR_W  = (STREAMS > 1) ? CH_W + ST_W : CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [CH_W-1:0] chan_q;
    logic            chan_wrap;

    always_comb begin
        chan_wrap = (chan_q == CH_W'(CHANNELS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            chan_q <= '0;
        end else if (inc) begin
            chan_q <= chan_wrap ? '0 : chan_q + 1'b1;
        end
    end

    generate
        if (STREAMS > 1) begin : g_multi
            logic [ST_W-1:0] strm_q;
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    strm_q <= '0;
                end else if (inc && chan_wrap) begin
                    strm_q <= (strm_q == ST_W'(STREAMS - 1)) ? '0 : strm_q + 1'b1;
                end
            end
            always_comb begin
                addr = {strm_q, chan_q};
                last = chan_wrap && (strm_q == ST_W'(STREAMS - 1));
            end
        end else begin : g_single
            always_comb begin
                addr = chan_q;
                last = chan_wrap;
            end
        end
    endgenerate

endmodule

// File: rtl/cmbp_seq.sv
module cmbp_seq
    import cmbp_pkg::*;
#(
    parameter int PAT_W  = 5,
    parameter int WORD_W = 16,
    localparam int LOW_W = WORD_W - PAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              arm_q,
    input  logic              start_q,
    input  logic [PAT_W-1:0]  pattern_in,
    input  logic              frame_pulse,
    input  logic              last,
    output logic              fill_en,
    output logic              cnt_clr,
    output logic              done,
    output logic              busy,
    output logic [WORD_W-1:0] wdata
);

    cmbp_state_e      state, state_nx;
    logic [1:0]       frames_q;
    logic [PAT_W-1:0] pat_lat;
    logic             abort;

    always_comb begin
        abort = !start_q || !arm_q;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (trig) state_nx = ST_WAIT_FRAME;
            ST_WAIT_FRAME: if (abort) state_nx = ST_IDLE;
                           else if (frame_pulse) state_nx = ST_FILL;
            ST_FILL:       if (abort) state_nx = ST_IDLE;
                           else if (last) state_nx = ST_HOLD;
            ST_HOLD:       if (abort) state_nx = ST_IDLE;
                           else if (frames_q == 2'(FILL_FRAMES)) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // state register with run bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            frames_q <= '0;
            pat_lat  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && trig) begin
                pat_lat <= pattern_in;
            end
            if (state == ST_IDLE || state == ST_WAIT_FRAME) begin
                frames_q <= '0;
            end else if (frame_pulse && frames_q != 2'(FILL_FRAMES)) begin
                frames_q <= frames_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        fill_en = (state == ST_FILL) && !abort;
        cnt_clr = (state != ST_FILL);
        done    = (state == ST_HOLD) && !abort && (frames_q == 2'(FILL_FRAMES));
        wdata   = {pat_lat, {LOW_W{1'b0}}};
    end

endmodule

// File: rtl/cmbp_block_prog.sv
module cmbp_block_prog #(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 128,
    parameter int PAT_W    = 5,
    parameter int WORD_W   = 16,
    localparam int ADDR_W  = $clog2(STREAMS * CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_arm_in,
    input  logic              mode_wr,
    input  logic              mode_start_in,
    input  logic [PAT_W-1:0]  mode_pattern_in,
    input  logic              frame_pulse,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_wdata,
    output logic              arm_q,
    output logic              start_q,
    output logic [PAT_W-1:0]  pattern_q,
    output logic              busy
);

    logic trig, done, fill_en, cnt_clr, last;

    cmbp_regs #(.PAT_W(PAT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_arm_in(ctl_arm_in),
        .mode_wr(mode_wr), .mode_start_in(mode_start_in),
        .mode_pattern_in(mode_pattern_in), .done(done),
        .arm_q(arm_q), .start_q(start_q), .pattern_q(pattern_q), .trig(trig)
    );

    cmbp_seq #(.PAT_W(PAT_W), .WORD_W(WORD_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .trig(trig), .arm_q(arm_q), .start_q(start_q),
        .pattern_in(mode_pattern_in), .frame_pulse(frame_pulse), .last(last),
        .fill_en(fill_en), .cnt_clr(cnt_clr), .done(done), .busy(busy),
        .wdata(cm_wdata)
    );

    cmbp_addr_gen #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) addr_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(fill_en),
        .addr(cm_addr), .last(last)
    );

    always_comb begin
        cm_we = fill_en;
    end

endmodule

// File: rtl/cmbp_block_prog_chk.sv
module cmbp_block_prog_chk #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 16,
    parameter int PAT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic              cm_we,
    input logic [ADDR_W-1:0] cm_addr,
    input logic [WORD_W-1:0] cm_wdata,
    input logic              arm_q,
    input logic              start_q,
    input logic              busy
);

    assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cm_we);

    assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cm_we) |-> (cm_addr == '0));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_we && $past(cm_we)) |-> (cm_addr == $past(cm_addr) + 1'b1));

    assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> (cm_wdata[WORD_W-PAT_W-1:0] == '0));

    assert_pattern_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_we && $past(cm_we)) |-> $stable(cm_wdata));

    assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_q) && !$past(mode_wr)) |-> !busy);

    assert_armed_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> arm_q);

    assert_started_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> start_q);

endmodule

bind cmbp_block_prog cmbp_block_prog_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cm_we(cm_we),
    .cm_addr(cm_addr), .cm_wdata(cm_wdata), .arm_q(arm_q),
    .start_q(start_q), .busy(busy)
);

// File: tb/cmbp_block_prog_tb_top.sv
`timescale 1ns/1ps
module cmbp_block_prog_tb_top;

    localparam int WORDS = 512;
    localparam int FRAME = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_arm_in = 1'b0;
    logic       mode_wr = 1'b0, mode_start_in = 1'b0;
    logic [4:0] mode_pattern_in = '0;
    logic       frame_pulse = 1'b0;
    logic       cm_we;
    logic [8:0] cm_addr;
    logic [15:0] cm_wdata;
    logic       arm_q, start_q, busy;
    logic [4:0] pattern_q;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int base = 0;
    int order_err = 0;
    logic [15:0] mem [WORDS];

    always #5 clk = ~clk;

    cmbp_block_prog dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_arm_in(ctl_arm_in),
        .mode_wr(mode_wr), .mode_start_in(mode_start_in),
        .mode_pattern_in(mode_pattern_in), .frame_pulse(frame_pulse),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
        .arm_q(arm_q), .start_q(start_q), .pattern_q(pattern_q), .busy(busy)
    );

    // memory model and ordering monitor
    always @(posedge clk) begin
        if (cm_we) begin
            if (int'(cm_addr) != ((wr_count - base) % WORDS)) order_err = order_err + 1;
            mem[cm_addr] = cm_wdata;
            wr_count = wr_count + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic arm);
        @(negedge clk); ctl_wr = 1'b1; ctl_arm_in = arm;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic st, input logic [4:0] pat);
        @(negedge clk); mode_wr = 1'b1; mode_start_in = st; mode_pattern_in = pat;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); frame_pulse = 1'b1;
        @(negedge clk); frame_pulse = 1'b0;
    endtask

    task automatic prep();
        for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
        base = wr_count;
        order_err = 0;
    endtask

    // vector: {arm, pattern}
    localparam logic [5:0] VEC [6] = '{6'b1_00000, 6'b1_11111, 6'b1_10101,
                                      6'b1_01010, 6'b0_10011, 6'b1_10011};

    initial begin
        cycles(3);
        // R1 reset state
        check("R1 arm", int'(arm_q), 0);
        check("R1 start", int'(start_q), 0);
        check("R1 pattern", int'(pattern_q), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 we", int'(cm_we), 0);
        @(negedge clk); rst_n = 1'b1;
        cycles(2);

        for (int v = 0; v < 6; v++) begin
            logic       arm;
            logic [4:0] pat;
            int         bad;
            arm = VEC[v][5];
            pat = VEC[v][4:0];
            wr_mode(1'b0, 5'd0);
            wr_ctl(arm);
            prep();
            wr_mode(1'b1, pat);
            cycles(3);
            check("R2 busy after trigger", int'(busy), int'(arm));
            check("R2 no write before frame", wr_count - base, 0);
            check("R6 start readback", int'(start_q), 1);
            pulse();
            cycles(FRAME);
            check("R3 writes after fill", wr_count - base, arm ? WORDS : 0);
            pulse();
            cycles(FRAME);
            check("R5 start held after first frame", int'(start_q), 1);
            pulse();
            cycles(4);
            check("R5 start self-clear", int'(start_q), arm ? 0 : 1);
            check("R5 busy low", int'(busy), 0);
            check("R3 total writes", wr_count - base, arm ? WORDS : 0);
            check("R3 ascending order", order_err, 0);
            bad = 0;
            for (int i = 0; i < WORDS; i++)
                if (mem[i] != (arm ? {pat, 11'b0} : 16'hFFFF)) bad++;
            check("R4 word contents", bad, 0);
        end

        // R9 arming with start already set does not trigger
        wr_mode(1'b0, 5'd0);
        wr_ctl(1'b0);
        wr_mode(1'b1, 5'h07);
        wr_ctl(1'b1);
        prep();
        pulse();
        cycles(FRAME);
        check("R9 no run without edge", wr_count - base, 0);
        check("R9 busy", int'(busy), 0);

        // R7 abort by clearing start
        wr_mode(1'b0, 5'h07);
        prep();
        wr_mode(1'b1, 5'h07);
        pulse();
        cycles(100);
        wr_mode(1'b0, 5'h07);
        begin
            int c0;
            c0 = wr_count - base;
            cycles(50);
            check("R7 writes stopped", wr_count - base, c0);
            check("R7 partial", int'(c0 > 0 && c0 < WORDS), 1);
            check("R7 busy", int'(busy), 0);
        end

        // R8 abort by clearing arm
        prep();
        wr_mode(1'b1, 5'h19);
        pulse();
        cycles(100);
        wr_ctl(1'b0);
        begin
            int c1;
            c1 = wr_count - base;
            cycles(50);
            check("R8 writes stopped", wr_count - base, c1);
            check("R8 partial", int'(c1 > 0 && c1 < WORDS), 1);
            check("R8 busy", int'(busy), 0);
            check("R8 start kept", int'(start_q), 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule